// File: doc/BRIEF.md
# Serial Tuning Word Controller

This block is the digital core of a programmable tuning capacitor. An 11-bit control word arrives one bit at a time on a serial data pin. Each rising edge of a serial clock pin shifts in one bit, bit 0 first. The block also holds a model of a nonvolatile stored word. That word can be cleared one bit per program strobe, erased in bulk, and read back one bit at a time.

The resting level of the serial clock picks which word sets the capacitance. When the clock rests high, the live shift register is used, and a 1 enables a capacitor. When the clock rests low, the stored word is used, and a 0 enables a capacitor. The chosen word splits into a coarse code, a mid code and a fine code. From these codes the block computes the total capacitance as an integer number of femtofarads.

All pins are sampled on the system clock, and every output follows the pin levels registered at the previous system clock edge. Programming voltages and analog banks are outside this block. The program pulse is modelled as a digital strobe.

Top module: `tw_ctrl`

## Requirements
- R1: On every system clock edge where `ser_clk` is high and was low at the previous edge, the shift word moves one place toward bit 0 and `ser_dat` enters at bit 10. After 11 such edges, the first bit sent sits at bit 0. The shift word does not change on any other edge.
- R2: The active word decodes as follows: the coarse code is bits 10:9, the mid code is bits 8:6 and the fine code is bits 5:1. Each code is plain binary with its higher bit more significant. Bit 0 has no effect on any output code or on the capacitance.
- R3: If `ser_clk` was high at the last edge, the active word is the shift word. Otherwise the active word is the bitwise inverse of the stored word.
- R4: `cap_ff_o` = 6600 + 6400·coarse + 1400·mid + 63·fine. It therefore stays within 6600 to 37553. For example, shift word 00000010100 gives fine code 10 and a total of 7230.
- R5: A rising edge of `prog_stb` while the shift word has exactly one 0 clears that bit position in the stored word. The stored word changes on no other edge, except through R6.
- R6: A rising edge of `prog_stb` while the shift word is all ones sets every stored bit to 1, the check bit 0 included.
- R7: A rising edge of `prog_stb` while the shift word has two or more 0 bits leaves the store unchanged and sets `multi_err_o`. Any other strobe clears `multi_err_o`.
- R8: `rb_valid_o` is 1 only when three conditions hold at the last edge: `ser_clk` was high, `ser_dat` was high, and the shift word has exactly one 0. `rb_bit_o` then equals the stored bit at that position. Otherwise both outputs are 0.
- R9: Reset leaves the stored word all ones, the shift word all zeros and `multi_err_o` low. With `ser_clk` low, the capacitance after reset is therefore 6600.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock pin level |
| ser_dat | input | 1 | Serial data pin level |
| prog_stb | input | 1 | Program strobe, acts on its rising edge |
| coarse_o | output | 2 | Coarse code of the active word |
| mid_o | output | 3 | Mid code of the active word |
| fine_o | output | 5 | Fine code of the active word |
| cap_ff_o | output | 16 | Total capacitance in fF |
| multi_err_o | output | 1 | Last strobe had more than one 0 bit |
| rb_valid_o | output | 1 | Readback bit is determinate |
| rb_bit_o | output | 1 | Selected stored bit |

## Verification
The assertions rely on three assumptions about the inputs. First, every pin is synchronous to the system clock and changes away from its edge. Second, `ser_clk` is low during reset, so the checker's own view of the edges matches the block's view. Third, each strobe is a pulse that returns low before the next one.

The bench drives every pin on the falling edge of the system clock. It holds each serial clock phase for a full system cycle and always releases a strobe before it shifts a new word. As a result, no stimulus ever steps outside these assumptions.

// File: rtl/tw_pkg.sv
package tw_pkg;
    parameter int unsigned WORD_W  = 11;
    parameter int unsigned CO_W    = 2;
    parameter int unsigned MID_W   = 3;
    parameter int unsigned FINE_W  = 5;
    parameter int unsigned CAP_W   = 16;
    parameter int unsigned BASE_FF = 6600;
    parameter int unsigned STEP_CO = 6400;
    parameter int unsigned STEP_MD = 1400;
    parameter int unsigned STEP_FN = 63;

    localparam int unsigned FINE_LSB = 1;
    localparam int unsigned MID_LSB  = FINE_LSB + FINE_W;
    localparam int unsigned CO_LSB   = MID_LSB + MID_W;
    localparam int unsigned CNT_W    = $clog2(WORD_W + 1);
    localparam int unsigned IDX_W    = $clog2(WORD_W);

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  cnt_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic [CO_W-1:0]   coarse;
        logic [MID_W-1:0]  mid;
        logic [FINE_W-1:0] fine;
    } codes_t;

    function automatic cnt_t zero_count(input word_t w);
        cnt_t c;
        c = '0;
        for (int i = 0; i < int'(WORD_W); i++)
            if (!w[i]) c = c + 1'b1;
        return c;
    endfunction

    function automatic idx_t zero_index(input word_t w);
        idx_t x;
        x = '0;
        for (int i = 0; i < int'(WORD_W); i++)
            if (!w[i]) x = IDX_W'(i);
        return x;
    endfunction

    function automatic codes_t split_word(input word_t w);
        codes_t c;
        c.coarse = w[CO_LSB +: CO_W];
        c.mid    = w[MID_LSB +: MID_W];
        c.fine   = w[FINE_LSB +: FINE_W];
        return c;
    endfunction

    function automatic logic [CAP_W-1:0] cap_of(input codes_t c);
        logic [31:0] acc;
        acc = BASE_FF + STEP_CO * 32'(c.coarse) + STEP_MD * 32'(c.mid)
            + STEP_FN * 32'(c.fine);
        return acc[CAP_W-1:0];
    endfunction
endpackage

// File: rtl/tw_shifter.sv
module tw_shifter
    import tw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  ser_clk,
    input  logic  ser_dat,
    output word_t word,
    output logic  sclk_lvl,
    output logic  dat_lvl
);
    logic rise;
    assign rise = ser_clk & ~sclk_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_lvl <= 1'b0;
            dat_lvl  <= 1'b0;
            word     <= '0;
        end else begin
            sclk_lvl <= ser_clk;
            dat_lvl  <= ser_dat;
            if (rise)
                word <= {ser_dat, word[WORD_W-1:1]};
        end
    end
endmodule

// File: rtl/tw_store.sv
module tw_store
    import tw_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  prog_stb,
    input  word_t sh_word,
    output word_t st_word,
    output logic  multi_err
);
    logic  stb_q;
    logic  stb_edge;
    cnt_t  nz;
    idx_t  zidx;
    word_t nxt;

    assign stb_edge = prog_stb & ~stb_q;
    assign nz       = zero_count(sh_word);
    assign zidx     = zero_index(sh_word);

    for (genvar g = 0; g < int'(WORD_W); g++) begin : g_bit
        always_comb begin
            nxt[g] = st_word[g];
            if (nz == '0)
                nxt[g] = 1'b1;
            else if (nz == CNT_W'(1) && zidx == IDX_W'(g))
                nxt[g] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stb_q     <= 1'b0;
            st_word   <= '1;
            multi_err <= 1'b0;
        end else begin
            stb_q <= prog_stb;
            if (stb_edge) begin
                st_word   <= nxt;
                multi_err <= (nz > CNT_W'(1));
            end
        end
    end
endmodule

// File: rtl/tw_decode.sv
module tw_decode
    import tw_pkg::*;
(
    input  logic             sclk_lvl,
    input  logic             dat_lvl,
    input  word_t            sh_word,
    input  word_t            st_word,
    output codes_t           codes,
    output logic [CAP_W-1:0] cap_ff,
    output logic             rb_valid,
    output logic             rb_bit
);
    word_t act;
    logic  one_zero;

    assign act      = sclk_lvl ? sh_word : ~st_word;
    assign codes    = split_word(act);
    assign cap_ff   = cap_of(codes);
    assign one_zero = (zero_count(sh_word) == CNT_W'(1));
    assign rb_valid = sclk_lvl & dat_lvl & one_zero;
    assign rb_bit   = rb_valid & st_word[zero_index(sh_word)];
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
    import tw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              prog_stb,
    output logic [CO_W-1:0]   coarse_o,
    output logic [MID_W-1:0]  mid_o,
    output logic [FINE_W-1:0] fine_o,
    output logic [CAP_W-1:0]  cap_ff_o,
    output logic              multi_err_o,
    output logic              rb_valid_o,
    output logic              rb_bit_o
);
    word_t  sh_word;
    word_t  st_word;
    logic   sclk_lvl;
    logic   dat_lvl;
    codes_t codes;

    tw_shifter u_shift (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .word(sh_word), .sclk_lvl(sclk_lvl), .dat_lvl(dat_lvl)
    );

    tw_store u_store (
        .clk(clk), .rst(rst), .prog_stb(prog_stb), .sh_word(sh_word),
        .st_word(st_word), .multi_err(multi_err_o)
    );

    tw_decode u_dec (
        .sclk_lvl(sclk_lvl), .dat_lvl(dat_lvl), .sh_word(sh_word),
        .st_word(st_word), .codes(codes), .cap_ff(cap_ff_o),
        .rb_valid(rb_valid_o), .rb_bit(rb_bit_o)
    );

    assign coarse_o = codes.coarse;
    assign mid_o    = codes.mid;
    assign fine_o   = codes.fine;
endmodule

// File: rtl/tw_ctrl_chk.sv
module tw_ctrl_chk
    import tw_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             ser_clk,
    input logic             ser_dat,
    input logic             prog_stb,
    input word_t            sh_word,
    input word_t            st_word,
    input logic [CAP_W-1:0] cap_ff_o,
    input logic             multi_err_o,
    input logic             rb_valid_o,
    input logic             rb_bit_o
);
    logic clk_prev, stb_prev;
    logic sedge, pedge;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev <= 1'b0;
            stb_prev <= 1'b0;
        end else begin
            clk_prev <= ser_clk;
            stb_prev <= prog_stb;
        end
    end

    assign sedge = ser_clk & ~clk_prev;
    assign pedge = prog_stb & ~stb_prev;

    // R1
    a_r1_shift_in: assert property (@(posedge clk) disable iff (rst)
        sedge |=> (sh_word[WORD_W-1] == $past(ser_dat)) &&
                  (sh_word[WORD_W-2:0] == $past(sh_word[WORD_W-1:1])));
    // R1
    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !sedge |=> $stable(sh_word));
    // R4
    a_r4_cap_range: assert property (@(posedge clk) disable iff (rst)
        (cap_ff_o >= CAP_W'(6600)) && (cap_ff_o <= CAP_W'(37553)));
    // R5
    a_r5_quiet: assert property (@(posedge clk) disable iff (rst)
        !pedge |=> $stable(st_word));
    // R5
    a_r5_single: assert property (@(posedge clk) disable iff (rst)
        (pedge && zero_count(sh_word) == CNT_W'(1)) |=>
        (st_word == ($past(st_word) & $past(sh_word))));
    // R6
    a_r6_erase: assert property (@(posedge clk) disable iff (rst)
        (pedge && (&sh_word)) |=> (&st_word));
    // R7
    a_r7_multi: assert property (@(posedge clk) disable iff (rst)
        (pedge && zero_count(sh_word) > CNT_W'(1)) |=>
        (multi_err_o && $stable(st_word)));
    // R8
    a_r8_rb_quiet: assert property (@(posedge clk) disable iff (rst)
        !rb_valid_o |-> !rb_bit_o);
    // R8
    a_r8_rb_levels: assert property (@(posedge clk) disable iff (rst)
        rb_valid_o |-> (clk_prev && $past(ser_dat)));
endmodule

bind tw_ctrl tw_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .prog_stb(prog_stb), .sh_word(sh_word), .st_word(st_word),
    .cap_ff_o(cap_ff_o), .multi_err_o(multi_err_o),
    .rb_valid_o(rb_valid_o), .rb_bit_o(rb_bit_o)
);

// File: tb/tb_tw_ctrl.sv
module tb_tw_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst, ser_clk, ser_dat, prog_stb;
    logic [1:0]  coarse_o;
    logic [2:0]  mid_o;
    logic [4:0]  fine_o;
    logic [15:0] cap_ff_o;
    logic multi_err_o, rb_valid_o, rb_bit_o;

    int checks = 0;
    int failures = 0;
    logic [10:0] m_store;
    logic        m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    tw_ctrl dut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .prog_stb(prog_stb), .coarse_o(coarse_o), .mid_o(mid_o),
        .fine_o(fine_o), .cap_ff_o(cap_ff_o), .multi_err_o(multi_err_o),
        .rb_valid_o(rb_valid_o), .rb_bit_o(rb_bit_o)
    );

    function automatic int exp_cap(input logic [10:0] w);
        return 6600 + 6400 * int'(w[10:9]) + 1400 * int'(w[8:6])
             + 63 * int'(w[5:1]);
    endfunction

    function automatic int zeros(input logic [10:0] w);
        int n = 0;
        for (int i = 0; i < 11; i++) if (!w[i]) n++;
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shift_word(input logic [10:0] w);
        for (int i = 0; i < 11; i++) begin
            @(negedge clk); ser_clk = 1'b0; ser_dat = w[i];
            @(negedge clk); ser_clk = 1'b1;
        end
        @(negedge clk);
    endtask

    task automatic strobe(input logic [10:0] w);
        int n;
        n = zeros(w);
        @(negedge clk); prog_stb = 1'b1;
        @(negedge clk); prog_stb = 1'b0;
        if (n == 0) begin
            m_store = '1; m_err = 1'b0;
        end else if (n == 1) begin
            m_store = m_store & w; m_err = 1'b0;
        end else m_err = 1'b1;
    endtask

    task automatic check_shift_mode(input logic [10:0] w, input string tag);
        chk(cap_ff_o == 16'(exp_cap(w)), {tag, " R4 shift cap"}, cap_ff_o, exp_cap(w));
        chk({coarse_o, mid_o, fine_o} == {w[10:9], w[8:6], w[5:1]},
            {tag, " R2 fields"}, {coarse_o, mid_o, fine_o}, {w[10:9], w[8:6], w[5:1]});
    endtask

    task automatic check_store_mode(input string tag);
        @(negedge clk); ser_clk = 1'b0;
        @(negedge clk);
        chk(cap_ff_o == 16'(exp_cap(~m_store)), {tag, " R3 R5 store cap"},
            cap_ff_o, exp_cap(~m_store));
        chk(multi_err_o == m_err, {tag, " R7 err"}, multi_err_o, m_err);
    endtask

    task automatic readback(input int k);
        logic [10:0] w;
        w = ~(11'd1 << k);
        shift_word(w);
        @(negedge clk); ser_dat = 1'b1;
        @(negedge clk);
        chk(rb_valid_o == 1'b1, "R8 rb valid", rb_valid_o, 1);
        chk(rb_bit_o == m_store[k], "R8 rb bit", rb_bit_o, m_store[k]);
        @(negedge clk); ser_clk = 1'b0;
        @(negedge clk);
        chk(rb_valid_o == 1'b0 && rb_bit_o == 1'b0, "R8 rb idle", rb_valid_o, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int unsigned r;
        logic [10:0] w;
        r = $urandom(32'd4242);
        rst = 1'b1; ser_clk = 1'b0; ser_dat = 1'b0; prog_stb = 1'b0;
        m_store = '1; m_err = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cap_ff_o == 16'd6600, "R9 reset cap", cap_ff_o, 6600);
        chk(multi_err_o == 1'b0, "R9 reset err", multi_err_o, 0);
        chk(rb_valid_o == 1'b0, "R9 reset rb", rb_valid_o, 0);

        // R1 R4: worked example, fine code 10
        shift_word(11'b00000010100);
        check_shift_mode(11'b00000010100, "ex");
        chk(fine_o == 5'd10 && cap_ff_o == 16'd7230, "R1 R4 example", cap_ff_o, 7230);
        // R4 top of range
        shift_word(11'h7FF);
        chk(cap_ff_o == 16'd37553, "R4 max", cap_ff_o, 37553);
        // R2 bit 0 ignored
        shift_word(11'h001);
        chk(cap_ff_o == 16'd6600 && fine_o == 5'd0, "R2 bit0 ignored", cap_ff_o, 6600);

        // R5: program bits 2 and 4 from erased state
        shift_word(11'h7FF); strobe(11'h7FF);
        shift_word(~11'h004 & 11'h7FF); strobe(~11'h004 & 11'h7FF);
        shift_word(~11'h010 & 11'h7FF); strobe(~11'h010 & 11'h7FF);
        check_store_mode("prog24");
        chk(cap_ff_o == 16'd7230, "R5 store example", cap_ff_o, 7230);
        // R7: two zeros leave store unchanged
        shift_word(11'h7F9); strobe(11'h7F9);
        check_store_mode("multi");
        chk(multi_err_o == 1'b1, "R7 multi flag", multi_err_o, 1);
        // R6: erase, check bit readback high
        shift_word(11'h7FF); strobe(11'h7FF);
        check_store_mode("erase");
        chk(cap_ff_o == 16'd6600, "R6 erased cap", cap_ff_o, 6600);
        readback(0);
        // program check bit 0, read it back low
        shift_word(11'h7FE); strobe(11'h7FE);
        readback(0);

        for (int it = 0; it < 40; it++) begin
            int op, k;
            w = 11'($urandom);
            shift_word(w);
            check_shift_mode(w, "R1 rand");
            check_store_mode("R5 rand quiet");
            op = int'($urandom % 4);
            k  = int'($urandom % 11);
            case (op)
                0: w = ~(11'd1 << k);
                1: w = 11'h7FF;
                2: w = 11'($urandom);
                default: w = 11'h7FF;
            endcase
            if (op == 3) readback(k);
            else begin
                shift_word(w); strobe(w);
                check_store_mode("R6 R7 rand strobe");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule